// File: doc/BRIEF.md
# Bus Error Capture Register

This block records which bus cycle was in flight at the moment a bus-cycle error was seen. An error is either the external bus-check input or the internal parity-check output qualified by the parity-enable input. When either one occurs, the block stores the cycle's attributes and its address in the same clock edge. The attributes are lock, memory versus I/O, data versus code, and write versus read. The stored words stay there until software looks at them.

Software reads the two stored words through a model-specific-register read port. The port takes an index and returns a 64-bit value combinationally. Reading the attribute word also drops its valid flag on the following clock edge. A software-written enable bit decides whether an error also raises a one-cycle machine-check exception request. The request is raised only when the bit was already set in the cycle before the error was recorded.

All pins are plain control and status signals. The read port has no handshake: a read completes in the cycle it is asserted and is never back-pressured.

Top module: `bus_err_capture`

## Requirements
- R1: When `bus_check` is high at a rising clock edge, the attribute word and the address word are both loaded at that edge.
- R2: When `parity_check` and `parity_enable` are both high at an edge, a capture happens at that edge. When `parity_check` is high with `parity_enable` low (and `bus_check` low), both stored words are left unchanged.
- R3: The attribute word is read at index 0x01. Its layout is: bit 0 = valid (1 after a capture), bit 1 = write (1) / read (0), bit 2 = data (1) / code (0), bit 3 = memory (1) / I/O (0), bit 4 = locked cycle. Bits 63:5 always read zero.
- R4: Index 0x00 returns the captured cycle address, zero-extended to 64 bits.
- R5: A read at index 0x01 returns the current word and then clears bit 0 at that edge. Bits 4:1 and the address word stay unchanged.
- R6: If a capture and a read at index 0x01 fall on the same edge, the capture wins and bit 0 is 1 afterwards.
- R7: A read at any index other than 0x00 or 0x01 returns zero and changes neither stored word.
- R8: `mc_exc_req` is raised only when the enable bit was 1 before the error edge. A write of the enable bit in the same cycle as the error does not count. The enable bit is set or cleared by `mce_en_wr` and `mce_en_din` and can be read on `mce_en`.
- R9: `mc_exc_req` is high for exactly the one cycle after the edge at which the error condition rises. An error held high over several cycles gives a single pulse.
- R10: After reset, both stored words are zero, the enable bit is 0 and `mc_exc_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_lock | input | 1 | Current cycle is locked |
| cyc_mem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| cyc_data | input | 1 | 1 = data cycle, 0 = code cycle |
| cyc_write | input | 1 | 1 = write, 0 = read |
| cyc_addr | input | ADDR_W | Current cycle address |
| bus_check | input | 1 | External bus error indication |
| parity_check | input | 1 | Internal parity error output |
| parity_enable | input | 1 | Qualifies `parity_check` |
| mce_en_wr | input | 1 | Write strobe for the exception enable bit |
| mce_en_din | input | 1 | Value written to the enable bit |
| mce_en | output | 1 | Current enable bit |
| msr_rd | input | 1 | Read strobe |
| msr_idx | input | IDX_W | Read index |
| msr_rdata | output | 64 | Read data (zero when `msr_rd` is low) |
| mc_exc_req | output | 1 | One-cycle machine-check exception request |

## Verification
The sweep tries every combination of the four cycle attributes under three triggers: bus check, parity check with enable, and parity check without enable. The first two must give identical captures. The third must leave the earlier word in place, which separates the two trigger paths and the parity qualifier. The enable bit is toggled across the sweep, so exception gating is seen in both states. Directed patterns cover:
- a held error, which separates edge detection from level detection;
- a read landing on a capture edge, which shows the capture winning;
- an enable write on the error cycle, which shows that only the earlier enable value counts;
- reads at stray indices, which must return zero and leave both words intact.

// File: rtl/bus_err_pkg.sv
package bus_err_pkg;
  localparam int unsigned REG_W = 64;

  typedef struct packed {
    logic lock;
    logic mem;
    logic data;
    logic write;
  } cyc_attr_t;

  function automatic logic [REG_W-1:0] attr_word(input cyc_attr_t a, input logic vld);
    logic [REG_W-1:0] w;
    w = '0;
    w[0] = vld;
    w[1] = a.write;
    w[2] = a.data;
    w[3] = a.mem;
    w[4] = a.lock;
    return w;
  endfunction
endpackage

// File: rtl/bus_err_detect.sv
module bus_err_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_check,
  input  logic parity_check,
  input  logic parity_enable,
  input  logic en_wr,
  input  logic en_din,
  output logic en_q,
  output logic capture,
  output logic exc_req
);
  logic cond_d;

  assign capture = bus_check | (parity_check & parity_enable);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      cond_d  <= 1'b0;
      exc_req <= 1'b0;
    end else begin
      if (en_wr) en_q <= en_din;
      cond_d  <= capture;
      exc_req <= capture & ~cond_d & en_q;
    end
  end

  // R8: a request implies the enable bit was set in the error cycle
  a_r8_enable_before: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> $past(en_q));
  // R9: never two request cycles in a row
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> !exc_req);
endmodule

// File: rtl/bus_err_store.sv
module bus_err_store
  import bus_err_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              clr_valid,
  input  cyc_attr_t         attr_in,
  input  logic [ADDR_W-1:0] addr_in,
  output cyc_attr_t         attr_q,
  output logic              valid_q,
  output logic [ADDR_W-1:0] addr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      attr_q  <= '0;
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else if (capture) begin
      attr_q  <= attr_in;
      valid_q <= 1'b1;
      addr_q  <= addr_in;
    end else if (clr_valid) begin
      valid_q <= 1'b0;
    end
  end

  // R1: a capture leaves the valid flag set (R6: even with a clear)
  a_r1_capture_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> valid_q);
  // R6: the captured address is the one presented
  a_r6_capture_addr: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> addr_q == $past(addr_in));
  // R5: the clear drops only the valid flag
  a_r5_clear_only_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid && !capture) |=> (!valid_q && $stable(attr_q) && $stable(addr_q)));
  // R2: without a capture the address holds
  a_r2_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(addr_q));
endmodule

// File: rtl/bus_err_readmux.sv
module bus_err_readmux
  import bus_err_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned IDX_W    = 8,
  parameter int unsigned IDX_ADDR = 0,
  parameter int unsigned IDX_TYPE = 1
) (
  input  logic              rd,
  input  logic [IDX_W-1:0]  idx,
  input  cyc_attr_t         attr_q,
  input  logic              valid_q,
  input  logic [ADDR_W-1:0] addr_q,
  output logic [REG_W-1:0]  rdata,
  output logic              clr_valid
);
  logic hit_addr, hit_type;

  assign hit_addr  = rd && (idx == IDX_W'(IDX_ADDR));
  assign hit_type  = rd && (idx == IDX_W'(IDX_TYPE));
  assign clr_valid = hit_type;

  always_comb begin
    rdata = '0;
    if (hit_addr)      rdata = REG_W'(addr_q);
    else if (hit_type) rdata = attr_word(attr_q, valid_q);
  end

  // R7: the clear strobe comes only from the attribute index
  always_comb begin
    if (clr_valid) a_r7_clear_index: assert (idx == IDX_W'(IDX_TYPE));
  end
endmodule

// File: rtl/bus_err_capture.sv
module bus_err_capture
  import bus_err_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_lock,
  input  logic              cyc_mem,
  input  logic              cyc_data,
  input  logic              cyc_write,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic              bus_check,
  input  logic              parity_check,
  input  logic              parity_enable,
  input  logic              mce_en_wr,
  input  logic              mce_en_din,
  output logic              mce_en,
  input  logic              msr_rd,
  input  logic [IDX_W-1:0]  msr_idx,
  output logic [REG_W-1:0]  msr_rdata,
  output logic              mc_exc_req
);
  logic              capture, clr_valid, valid_q;
  cyc_attr_t         attr_in, attr_q;
  logic [ADDR_W-1:0] addr_q;

  assign attr_in = '{lock: cyc_lock, mem: cyc_mem, data: cyc_data, write: cyc_write};

  bus_err_detect u_detect (
    .clk(clk), .rst_n(rst_n),
    .bus_check(bus_check), .parity_check(parity_check), .parity_enable(parity_enable),
    .en_wr(mce_en_wr), .en_din(mce_en_din), .en_q(mce_en),
    .capture(capture), .exc_req(mc_exc_req)
  );

  bus_err_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .capture(capture), .clr_valid(clr_valid),
    .attr_in(attr_in), .addr_in(cyc_addr),
    .attr_q(attr_q), .valid_q(valid_q), .addr_q(addr_q)
  );

  bus_err_readmux #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_rd (
    .rd(msr_rd), .idx(msr_idx), .attr_q(attr_q), .valid_q(valid_q), .addr_q(addr_q),
    .rdata(msr_rdata), .clr_valid(clr_valid)
  );

  // R3: reserved upper bits of the read data stay zero on a type read
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd && msr_idx == IDX_W'(1)) |-> msr_rdata[REG_W-1:5] == '0);
endmodule

// File: tb/bus_err_capture_test.sv
module bus_err_capture_test;
  localparam int AW = 32;
  localparam int IW = 8;

  logic clk = 0, rst_n = 0;
  logic cyc_lock = 0, cyc_mem = 0, cyc_data = 0, cyc_write = 0;
  logic [AW-1:0] cyc_addr = '0;
  logic bus_check = 0, parity_check = 0, parity_enable = 0;
  logic mce_en_wr = 0, mce_en_din = 0, mce_en;
  logic msr_rd = 0;
  logic [IW-1:0] msr_idx = '0;
  logic [63:0] msr_rdata;
  logic mc_exc_req;

  int errors = 0, checks = 0;
  logic [63:0] exp_type, exp_addr;
  logic [63:0] got;

  always #5 clk = ~clk;

  bus_err_capture #(.ADDR_W(AW), .IDX_W(IW)) uut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [IW-1:0] idx, output logic [63:0] d);
    msr_rd = 1; msr_idx = idx;
    #1 d = msr_rdata;
    @(negedge clk);
    msr_rd = 0; msr_idx = '0;
  endtask

  task automatic set_en(input logic v);
    mce_en_wr = 1; mce_en_din = v;
    @(negedge clk);
    mce_en_wr = 0;
  endtask

  task automatic present(input logic [3:0] c, input logic [AW-1:0] a);
    {cyc_lock, cyc_mem, cyc_data, cyc_write} = c;
    cyc_addr = a;
  endtask

  function automatic logic [63:0] type_of(input logic [3:0] c, input logic v);
    return {59'b0, c[3], c[2], c[1], c[0], v};
  endfunction

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    exp_type = '0; exp_addr = '0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10 enable", 64'(mce_en), 0);
    chk("R10 exc", 64'(mc_exc_req), 0);
    do_read(8'h00, got); chk("R10 addr", got, 0);
    do_read(8'h01, got); chk("R10 type", got, 0);

    for (int trig = 0; trig < 3; trig++) begin
      for (int c = 0; c < 16; c++) begin
        logic en_set, cap;
        logic [AW-1:0] a;
        en_set = ((c + trig) % 3) != 0;
        cap = (trig != 2);
        a = 32'hA500_0000 ^ (32'(c) * 32'h0101_0101) ^ (32'(trig) << 28);
        set_en(en_set);
        chk("R8 enable readback", 64'(mce_en), 64'(en_set));
        present(4'(c), a);
        bus_check = (trig == 0);
        parity_check = (trig != 0);
        parity_enable = (trig == 1);
        @(negedge clk);
        bus_check = 0; parity_check = 0; parity_enable = 0;
        present(4'(~c), ~a);
        if (cap) begin
          exp_type = type_of(4'(c), 1'b1);
          exp_addr = 64'(a);
        end
        chk(cap ? "R8 R9 request" : "R2 no request", 64'(mc_exc_req), 64'(cap && en_set));
        do_read(8'h00, got);
        chk(cap ? "R1 R4 address" : "R2 address kept", got, exp_addr);
        chk("R9 pulse ends", 64'(mc_exc_req), 0);
        do_read(8'h01, got);
        chk(cap ? "R1 R3 type" : "R2 type kept", got, exp_type);
        exp_type[0] = 1'b0;
        do_read(8'h01, got);
        chk("R5 valid cleared", got, exp_type);
        do_read(IW'(2 + c * 15), got);
        chk("R7 stray index zero", got, 0);
        do_read(8'h00, got);
        chk("R7 address intact", got, exp_addr);
      end
    end

    // R9: held error gives one pulse
    set_en(1);
    present(4'hF, 32'h1234_5678);
    bus_check = 1;
    @(negedge clk);
    chk("R9 held first", 64'(mc_exc_req), 1);
    @(negedge clk);
    chk("R9 held second", 64'(mc_exc_req), 0);
    @(negedge clk);
    chk("R9 held third", 64'(mc_exc_req), 0);
    bus_check = 0;
    @(negedge clk);

    // R6: capture and clear on the same edge
    present(4'h5, 32'hCAFE_0001);
    bus_check = 1;
    do_read(8'h01, got);
    bus_check = 0;
    do_read(8'h01, got);
    chk("R6 capture wins", got, type_of(4'h5, 1'b1));
    do_read(8'h00, got);
    chk("R6 address", got, 64'h0000_0000_CAFE_0001);

    // R8: enable written in the error cycle does not count
    set_en(0);
    @(negedge clk);
    mce_en_wr = 1; mce_en_din = 1;
    parity_check = 1; parity_enable = 1;
    @(negedge clk);
    mce_en_wr = 0; parity_check = 0; parity_enable = 0;
    chk("R8 same-cycle enable", 64'(mc_exc_req), 0);
    chk("R8 enable now set", 64'(mce_en), 1);
    @(negedge clk);
    parity_check = 1; parity_enable = 1;
    @(negedge clk);
    parity_check = 0; parity_enable = 0;
    chk("R8 enabled earlier", 64'(mc_exc_req), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule